// File: doc/BRIEF.md
# Lockable Two-Domain Watchdog Timer

This block is a watchdog whose software-facing registers live in a fast bus clock domain while its counter runs from a slow, low-frequency clock. Software writes a control word that arms the counter, picks the timeout length, an optional early warning point and an optional early-clear window. Software feeds the watchdog by issuing a clear command. If the counter reaches the selected timeout without a clear, the block raises a system reset request.

Each of the two registers (control and command) crosses into the slow domain through its own toggle handshake. Each has its own busy flag, which stays high until the slow side has taken the value. A write that arrives while its register is busy is dropped. A lock bit freezes the control word until the next reset, so a runaway program cannot disable the watchdog. A reset-disable bit turns a timeout into a status flag only. A debug-halt input pauses counting unless the control word allows running under debug.

Top module: `lockable_wdt`

## Requirements
- R1: Once reset has been applied, `ctrl_rd_o` is all zero, both busy flags are low and `rst_req_o`, `timeout_o`, `warn_irq_o` and `win_viol_o` are low.
- R2: An accepted control write is read back unchanged on `ctrl_rd_o`. The bit layout is: 0 enable, 1 run-in-debug, 2 and 3 low-power run bits, 4 deep-sleep block, 5 oscillator-off block, 6 lock, 7 reset-disable, 9:8 clock select, 11:10 warning select, 14:12 window select, 18:15 period select.
- R3: `ctrl_busy_o` is high from the bus edge that accepts a control write until the slow domain has loaded it. A control write made while `ctrl_busy_o` is high is dropped and leaves `ctrl_rd_o` unchanged.
- R4: A command write raises `cmd_busy_o` only. `ctrl_busy_o` is not affected.
- R5: Slow rising edges are counted from the first slow edge after the bus edge that accepts a write (edge 1). The slow domain applies the write at edge 3. With enable set and period code p, `rst_req_o` and `timeout_o` rise at edge T+3, where T = 2^(3+p)+1.
- R6: A command write with `cmd_clear_i` high zeroes the counter at its edge 3. Without a further clear, the reset request then follows T slow edges later (edge T+3 of the clear write).
- R7: While the stored lock bit is set, control writes are ignored and `ctrl_busy_o` stays low. Only reset clears the lock.
- R8: With reset-disable set, a timeout sets `timeout_o` but never `rst_req_o`, and the counter restarts from zero.
- R9: Warning select s (1..3) sets `warn_irq_o` at edge W+3 after the enabling write, with W = floor(T*s/4). Code 0 never sets it.
- R10: Window select n (1..7) applies to a clear that takes effect while the count is below floor(T*n/8). Such a clear sets `win_viol_o` at the clear's edge 3, and also `rst_req_o` unless reset-disable is set. At or above that count, the clear is accepted silently.
- R11: With run-in-debug clear, every slow edge that samples `dbg_halt_i` high leaves the count unchanged, so the timeout moves later by that many edges. With run-in-debug set, `dbg_halt_i` has no effect.
- R12: If a clear takes effect on the same slow edge as a timeout, the clear wins: no reset request is raised, and the next timeout falls T edges later.
- R13: `rst_req_o`, `timeout_o` and `win_viol_o` stay high until reset. `warn_irq_o` is cleared by the next clear command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast register clock |
| lf_clk | input | 1 | Slow counter clock |
| rst_ni | input | 1 | Active-low reset, synchronous in each domain |
| ctrl_wr_i | input | 1 | Control write strobe (bus domain) |
| ctrl_wdata_i | input | 19 | Control write data |
| cmd_wr_i | input | 1 | Command write strobe (bus domain) |
| cmd_clear_i | input | 1 | Clear command bit of the command write |
| dbg_halt_i | input | 1 | Debugger halt level (slow domain) |
| ctrl_rd_o | output | 19 | Stored control word |
| ctrl_busy_o | output | 1 | Control transfer in progress |
| cmd_busy_o | output | 1 | Command transfer in progress |
| rst_req_o | output | 1 | System reset request |
| timeout_o | output | 1 | Timeout status flag |
| warn_irq_o | output | 1 | Warning interrupt flag |
| win_viol_o | output | 1 | Early-clear window violation flag |

## Verification
The clear command and the timeout can fall on the same slow edge. This is provoked by enabling with a short period and placing a clear write exactly T slow edges after the enabling write, so that both land together. The result is judged by checking that the reset request stays low at that edge and rises exactly T edges later. The window boundary is probed from both sides by clear writes one slow edge apart. These are judged by the violation flag and the reset request a fixed three edges after each write.

// File: rtl/wdt_pkg.sv
// Shared types for the lockable watchdog.
// Assumes: control layout is fixed; only the slow-side subset is carried to the counter.
package wdt_pkg;
    localparam int PER_W  = 4;
    localparam int WARN_W = 2;
    localparam int WIN_W  = 3;
    localparam int CSEL_W = 2;

    // Software-visible control word, bit 0 is the enable bit.
    typedef struct packed {
        logic [PER_W-1:0]  per;
        logic [WIN_W-1:0]  win;
        logic [WARN_W-1:0] warn;
        logic [CSEL_W-1:0] clk_sel;
        logic              rst_dis;
        logic              lock;
        logic              osc_blk;
        logic              deep_blk;
        logic              lp2_run;
        logic              lp1_run;
        logic              dbg_run;
        logic              en;
    } ctrl_t;

    localparam int CTRL_W     = $bits(ctrl_t);
    localparam int LOCK_BIT   = 6;
    localparam int RSTDIS_BIT = 7;

    // Fields the slow-domain counter acts on.
    typedef struct packed {
        logic [PER_W-1:0]  per;
        logic [WIN_W-1:0]  win;
        logic [WARN_W-1:0] warn;
        logic              rst_dis;
        logic              dbg_run;
        logic              en;
    } core_cfg_t;
endpackage

// File: rtl/wdt_xfer.sv
// Carries one bus-side register into the slow domain with a toggle handshake.
// Assumes: rst_ni is synchronous to each clock it is used with; the holding
// register is stable while busy, so the slow side may read it directly.
module wdt_xfer #(
    parameter int W = 1
) (
    input  logic         bus_clk,
    input  logic         lf_clk,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] data_i,
    input  logic         accept_i,
    output logic [W-1:0] hold_o,
    output logic         busy_o,
    output logic         lf_pulse_o
);
    logic tgl_q, ack_s1, ack_s2;
    logic req_s1, req_s2, req_s3, ack_q;

    assign busy_o     = tgl_q ^ ack_s2;
    assign lf_pulse_o = req_s2 ^ req_s3;

    // Bus side: capture an allowed write and flip the request toggle.
    always_ff @(posedge bus_clk) begin
        if (!rst_ni) begin
            hold_o <= '0;
            tgl_q  <= 1'b0;
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack_q;
            ack_s2 <= ack_s1;
            if (wr_i && accept_i && !busy_o) begin
                hold_o <= data_i;
                tgl_q  <= ~tgl_q;
            end
        end
    end

    // Slow side: synchronise the toggle, detect its change and return an acknowledge.
    always_ff @(posedge lf_clk) begin
        if (!rst_ni) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
            ack_q  <= 1'b0;
        end else begin
            req_s1 <= tgl_q;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
            ack_q  <= req_s3;
        end
    end
endmodule

// File: rtl/wdt_core.sv
// Slow-domain counter: timeout, warning and early-clear window.
// Assumes: cfg_i and clr_i are valid whenever the matching load/clear strobe is high.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int PER_BASE = 3
) (
    input  logic      lf_clk,
    input  logic      rst_ni,
    input  logic      cfg_load_i,
    input  core_cfg_t cfg_i,
    input  logic      clr_i,
    input  logic      dbg_halt_i,
    output logic      rst_req_o,
    output logic      timeout_o,
    output logic      warn_o,
    output logic      win_o
);
    localparam int CNT_W = PER_BASE + (1 << PER_W);
    localparam int LIM_W = CNT_W + 3;

    core_cfg_t        cfg;
    logic [CNT_W-1:0] cnt, cnt_inc, tmo_lim, warn_lim, win_lim;
    logic [LIM_W-1:0] warn_prod, win_prod;
    logic             run, hit_tmo, hit_warn, early;

    // Limits derived from the loaded configuration.
    always_comb begin
        tmo_lim   = (CNT_W'(1) << (PER_BASE + int'(cfg.per))) + 1'b1;
        warn_prod = {3'b000, tmo_lim} * LIM_W'(cfg.warn);
        win_prod  = {3'b000, tmo_lim} * LIM_W'(cfg.win);
        warn_lim  = CNT_W'(warn_prod >> 2);
        win_lim   = CNT_W'(win_prod >> 3);
        cnt_inc   = cnt + 1'b1;
        run       = cfg.en && (cfg.dbg_run || !dbg_halt_i);
        hit_tmo   = run && (cnt_inc == tmo_lim);
        hit_warn  = run && (cfg.warn != '0) && (cnt_inc == warn_lim);
        early     = cfg.en && (cfg.win != '0) && (cnt < win_lim);
    end

    // Configuration register, loaded when a control transfer lands.
    always_ff @(posedge lf_clk) begin
        if (!rst_ni)         cfg <= '0;
        else if (cfg_load_i) cfg <= cfg_i;
    end

    // Counter: clear has priority over counting and timeout.
    always_ff @(posedge lf_clk) begin
        if (!rst_ni)      cnt <= '0;
        else if (clr_i)   cnt <= '0;
        else if (hit_tmo) cnt <= '0;
        else if (run)     cnt <= cnt_inc;
    end

    // Status flags and reset request.
    always_ff @(posedge lf_clk) begin
        if (!rst_ni) begin
            rst_req_o <= 1'b0;
            timeout_o <= 1'b0;
            warn_o    <= 1'b0;
            win_o     <= 1'b0;
        end else if (clr_i) begin
            warn_o <= 1'b0;
            if (early) begin
                win_o <= 1'b1;
                if (!cfg.rst_dis) rst_req_o <= 1'b1;
            end
        end else begin
            if (hit_warn) warn_o <= 1'b1;
            if (hit_tmo) begin
                timeout_o <= 1'b1;
                if (!cfg.rst_dis) rst_req_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lockable_wdt.sv
// Watchdog top: bus-side registers with lock, two transfers, slow counter.
// Assumes: rst_ni is held low for at least one edge of each clock and is
// synchronous to both; dbg_halt_i is synchronous to lf_clk.
module lockable_wdt
    import wdt_pkg::*;
#(
    parameter int PER_BASE = 3
) (
    input  logic              bus_clk,
    input  logic              lf_clk,
    input  logic              rst_ni,
    input  logic              ctrl_wr_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              cmd_wr_i,
    input  logic              cmd_clear_i,
    input  logic              dbg_halt_i,
    output logic [CTRL_W-1:0] ctrl_rd_o,
    output logic              ctrl_busy_o,
    output logic              cmd_busy_o,
    output logic              rst_req_o,
    output logic              timeout_o,
    output logic              warn_irq_o,
    output logic              win_viol_o
);
    ctrl_t             ctrl_q;
    logic [CTRL_W-1:0] ctrl_hold;
    logic              ctrl_pulse, cmd_pulse, cmd_hold, cmd_clr;
    core_cfg_t         core_cfg;

    assign ctrl_q    = ctrl_t'(ctrl_hold);
    assign ctrl_rd_o = ctrl_hold;
    assign cmd_clr   = cmd_pulse & cmd_hold;

    // Subset of the control word the counter needs.
    always_comb begin
        core_cfg.per     = ctrl_q.per;
        core_cfg.win     = ctrl_q.win;
        core_cfg.warn    = ctrl_q.warn;
        core_cfg.rst_dis = ctrl_q.rst_dis;
        core_cfg.dbg_run = ctrl_q.dbg_run;
        core_cfg.en      = ctrl_q.en;
    end

    wdt_xfer #(.W(CTRL_W)) u_ctrl_xfer (
        .bus_clk    (bus_clk),
        .lf_clk     (lf_clk),
        .rst_ni     (rst_ni),
        .wr_i       (ctrl_wr_i),
        .data_i     (ctrl_wdata_i),
        .accept_i   (!ctrl_q.lock),
        .hold_o     (ctrl_hold),
        .busy_o     (ctrl_busy_o),
        .lf_pulse_o (ctrl_pulse)
    );

    wdt_xfer #(.W(1)) u_cmd_xfer (
        .bus_clk    (bus_clk),
        .lf_clk     (lf_clk),
        .rst_ni     (rst_ni),
        .wr_i       (cmd_wr_i),
        .data_i     (cmd_clear_i),
        .accept_i   (1'b1),
        .hold_o     (cmd_hold),
        .busy_o     (cmd_busy_o),
        .lf_pulse_o (cmd_pulse)
    );

    wdt_core #(.PER_BASE(PER_BASE)) u_core (
        .lf_clk     (lf_clk),
        .rst_ni     (rst_ni),
        .cfg_load_i (ctrl_pulse),
        .cfg_i      (core_cfg),
        .clr_i      (cmd_clr),
        .dbg_halt_i (dbg_halt_i),
        .rst_req_o  (rst_req_o),
        .timeout_o  (timeout_o),
        .warn_o     (warn_irq_o),
        .win_o      (win_viol_o)
    );
endmodule

// File: rtl/wdt_chk.sv
// Protocol checks for the watchdog, attached to the top by bind.
module wdt_chk
    import wdt_pkg::*;
(
    input logic              bus_clk,
    input logic              lf_clk,
    input logic              rst_ni,
    input logic              ctrl_wr,
    input logic              cmd_wr,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              ctrl_busy,
    input logic              cmd_clr,
    input logic              rst_req,
    input logic              tmo,
    input logic              warn,
    input logic              win
);
    AST_LOCK_FREEZE: assert property (@(posedge bus_clk) disable iff (!rst_ni)
        ctrl_q[LOCK_BIT] |=> $stable(ctrl_q)); // R7
    AST_BUSY_DROP: assert property (@(posedge bus_clk) disable iff (!rst_ni)
        (ctrl_wr && ctrl_busy) |=> $stable(ctrl_q)); // R3
    AST_CMD_SEPARATE: assert property (@(posedge bus_clk) disable iff (!rst_ni)
        (cmd_wr && !ctrl_wr && !ctrl_busy) |=> !ctrl_busy); // R4
    AST_RST_STICKY: assert property (@(posedge lf_clk) disable iff (!rst_ni)
        rst_req |=> rst_req); // R13
    AST_TMO_STICKY: assert property (@(posedge lf_clk) disable iff (!rst_ni)
        tmo |=> tmo); // R13
    AST_RSTDIS_QUIET: assert property (@(posedge lf_clk) disable iff (!rst_ni)
        (ctrl_q[RSTDIS_BIT] && !ctrl_busy && !rst_req) |=> !rst_req); // R8
    AST_WARN_CLEAR: assert property (@(posedge lf_clk) disable iff (!rst_ni)
        cmd_clr |=> !warn); // R13
    AST_WIN_CAUSE: assert property (@(posedge lf_clk) disable iff (!rst_ni)
        $rose(win) |-> $past(cmd_clr)); // R10
endmodule

bind lockable_wdt wdt_chk u_chk (
    .bus_clk   (bus_clk),
    .lf_clk    (lf_clk),
    .rst_ni    (rst_ni),
    .ctrl_wr   (ctrl_wr_i),
    .cmd_wr    (cmd_wr_i),
    .ctrl_q    (ctrl_rd_o),
    .ctrl_busy (ctrl_busy_o),
    .cmd_clr   (cmd_clr),
    .rst_req   (rst_req_o),
    .tmo       (timeout_o),
    .warn      (warn_irq_o),
    .win       (win_viol_o)
);

// File: tb/tb_lockable_wdt.sv
module tb_lockable_wdt;
    logic        bus_clk = 1'b0, lf_clk = 1'b0, rst_ni = 1'b0;
    logic        ctrl_wr = 1'b0, cmd_wr = 1'b0, cmd_clear = 1'b0, dbg_halt = 1'b0;
    logic [18:0] ctrl_wdata = '0;
    logic [18:0] ctrl_rd;
    logic        ctrl_busy, cmd_busy, rst_req, tmo, warn, win;
    int          n_chk = 0, n_err = 0;

    always #2 bus_clk = ~bus_clk;
    initial begin
        #1;
        forever begin lf_clk = 1'b1; #21; lf_clk = 1'b0; #21; end
    end

    lockable_wdt dut (
        .bus_clk(bus_clk), .lf_clk(lf_clk), .rst_ni(rst_ni),
        .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
        .cmd_wr_i(cmd_wr), .cmd_clear_i(cmd_clear), .dbg_halt_i(dbg_halt),
        .ctrl_rd_o(ctrl_rd), .ctrl_busy_o(ctrl_busy), .cmd_busy_o(cmd_busy),
        .rst_req_o(rst_req), .timeout_o(tmo), .warn_irq_o(warn), .win_viol_o(win)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [18:0] cw(bit en, bit dbg, bit lock, bit rdis,
                                       logic [1:0] ws, logic [2:0] wn, logic [3:0] per);
        return {per, wn, ws, 2'b00, rdis, lock, 4'b0000, dbg, en};
    endfunction

    function automatic int tlim(int p);
        return (1 << (3 + p)) + 1;
    endfunction

    function automatic logic flag(int which);
        case (which)
            0: return rst_req;
            1: return tmo;
            2: return warn;
            default: return win;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge bus_clk) rst_ni = 1'b0;
        dbg_halt = 1'b0;
        repeat (3) @(posedge lf_clk);
        @(negedge bus_clk) rst_ni = 1'b1;
        @(negedge lf_clk);
    endtask

    task automatic wr_ctrl(input logic [18:0] d);
        @(negedge bus_clk); ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge bus_clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_clr();
        @(negedge bus_clk); cmd_wr = 1'b1; cmd_clear = 1'b1;
        @(negedge bus_clk); cmd_wr = 1'b0; cmd_clear = 1'b0;
    endtask

    task automatic skip(input int k);
        repeat (k) @(posedge lf_clk);
        @(negedge lf_clk);
    endtask

    task automatic edges_until(input int which, output int n);
        n = -1;
        for (int i = 1; i <= 400; i++) begin
            @(posedge lf_clk); @(negedge lf_clk);
            if (flag(which)) begin n = i; break; end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && (ctrl_busy || cmd_busy); i++) @(negedge bus_clk);
        @(negedge bus_clk);
    endtask

    initial begin
        #600000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        @(negedge bus_clk);
        chk(ctrl_rd == '0 && !ctrl_busy && !cmd_busy, "R1 regs", int'(ctrl_rd), 0);
        chk({rst_req, tmo, warn, win} == 4'b0, "R1 flags", int'({rst_req, tmo, warn, win}), 0);

        // R5: timeout sweep over period codes
        for (int p = 0; p < 4; p++) begin
            do_reset();
            wr_ctrl(cw(1, 0, 0, 0, 2'd0, 3'd0, 4'(p)));
            edges_until(0, n);
            chk(n == tlim(p) + 3, "R5 rst edge", n, tlim(p) + 3);
            chk(tmo == 1'b1, "R5 timeout flag", int'(tmo), 1);
        end

        // R9: warning sweep
        for (int p = 0; p < 4; p++) begin
            for (int s = 1; s < 4; s++) begin
                do_reset();
                wr_ctrl(cw(1, 0, 0, 0, 2'(s), 3'd0, 4'(p)));
                edges_until(2, n);
                chk(n == ((tlim(p) * s) >> 2) + 3, "R9 warn edge", n, ((tlim(p) * s) >> 2) + 3);
            end
        end
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd0, 3'd0, 4'd0));
        edges_until(0, n);
        chk(warn == 1'b0, "R9 warn off", int'(warn), 0);

        // R2, R3, R4: readback, busy, drop, separate command busy
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd2, 3'd1, 4'd3) | 19'h0033C);
        chk(ctrl_busy == 1'b1, "R3 busy high", int'(ctrl_busy), 1);
        chk(cmd_busy == 1'b0, "R4 cmd idle", int'(cmd_busy), 0);
        wr_ctrl(19'h00000);
        wait_idle();
        chk(ctrl_rd == (cw(1, 0, 0, 0, 2'd2, 3'd1, 4'd3) | 19'h0033C), "R2 R3 readback",
            int'(ctrl_rd), int'(cw(1, 0, 0, 0, 2'd2, 3'd1, 4'd3) | 19'h0033C));
        wr_clr();
        chk(cmd_busy == 1'b1, "R4 cmd busy", int'(cmd_busy), 1);
        chk(ctrl_busy == 1'b0, "R4 ctrl idle", int'(ctrl_busy), 0);
        wait_idle();
        chk(cmd_busy == 1'b0, "R4 cmd done", int'(cmd_busy), 0);

        // R6: clear restarts the count
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd0, 3'd0, 4'd1));
        skip(10);
        wr_clr();
        edges_until(0, n);
        chk(n == tlim(1) + 3, "R6 clear restart", n, tlim(1) + 3);

        // R12: clear and timeout on the same slow edge
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd0, 3'd0, 4'd1));
        skip(tlim(1));
        wr_clr();
        skip(3);
        chk(rst_req == 1'b0, "R12 clear wins", int'(rst_req), 0);
        edges_until(0, n);
        chk(n == tlim(1), "R12 next timeout", n, tlim(1));

        // R10: window boundary from both sides (T=33, n=4, limit 16)
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd0, 3'd4, 4'd2));
        skip(16);
        wr_clr();
        edges_until(3, n);
        chk(n == 3, "R10 early clear", n, 3);
        chk(rst_req == 1'b1, "R10 early reset", int'(rst_req), 1);
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd0, 3'd4, 4'd2));
        skip(17);
        wr_clr();
        skip(3);
        chk(win == 1'b0 && rst_req == 1'b0, "R10 in-window clear", int'({win, rst_req}), 0);

        // R13: warning cleared by clear, window flag sticky
        do_reset();
        wr_ctrl(cw(1, 0, 0, 0, 2'd1, 3'd0, 4'd2));
        skip(12);
        chk(warn == 1'b1, "R13 warn set", int'(warn), 1);
        wr_clr();
        skip(3);
        chk(warn == 1'b0, "R13 warn cleared", int'(warn), 0);

        // R8: reset-disable
        do_reset();
        wr_ctrl(cw(1, 0, 0, 1, 2'd0, 3'd0, 4'd0));
        edges_until(1, n);
        chk(n == tlim(0) + 3, "R8 timeout edge", n, tlim(0) + 3);
        skip(30);
        chk(rst_req == 1'b0 && tmo == 1'b1, "R8 no reset", int'({rst_req, tmo}), 1);

        // R11: debug halt with and without run-in-debug
        for (int d = 0; d < 2; d++) begin
            do_reset();
            wr_ctrl(cw(1, d[0], 0, 0, 2'd0, 3'd0, 4'd1));
            skip(5);
            dbg_halt = 1'b1;
            skip(7);
            dbg_halt = 1'b0;
            edges_until(0, n);
            chk(n == (d == 0 ? 15 : 8), "R11 halt", n, (d == 0 ? 15 : 8));
        end

        // R7: lock freezes control until reset
        do_reset();
        wr_ctrl(cw(1, 0, 1, 0, 2'd0, 3'd0, 4'd0));
        wait_idle();
        wr_ctrl(19'h00000);
        chk(ctrl_busy == 1'b0, "R7 write ignored", int'(ctrl_busy), 0);
        chk(ctrl_rd == cw(1, 0, 1, 0, 2'd0, 3'd0, 4'd0), "R7 frozen", int'(ctrl_rd),
            int'(cw(1, 0, 1, 0, 2'd0, 3'd0, 4'd0)));
        edges_until(0, n);
        chk(n > 0, "R7 still armed", n, 1);
        do_reset();
        @(negedge bus_clk);
        chk(ctrl_rd == '0, "R7 reset unlocks", int'(ctrl_rd), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule